// File: doc/BRIEF.md
# Serial Instruction Clock-Count Guard

This block sits beside the instruction decoder of a serial-access non-volatile memory. It counts rising edges of the serial clock. Counting begins at the edge that samples the start bit and ends when chip select is released. When chip select falls, it compares the count with the exact frame length that the decoded instruction needs in the selected organization. An extra clock from a glitch shifts every address and data bit by one place. This guard turns such a frame into an abort pulse instead of a corrupted program cycle.

The decoder supplies single-cycle strobes that are already synchronized to the system clock: a serial-clock rising edge, start-bit detect and chip-select fall. It also supplies the decoded instruction class and the organization bit. One cycle after the chip-select-fall strobe the guard raises either `commit`, which lets the self-timed program cycle start, or `abort`, which leaves the array untouched. Read frames stream without a fixed length, so the guard never judges them. The word-mode address width is a parameter, so one netlist covers every array size.

Top module: `ccc_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `commit` and `abort` are both low.
- R2: The count starts at 1 on the serial-clock strobe that comes with `start_bit`. Serial-clock strobes that arrive before any start bit are not counted.
- R3: The expected length is 3 plus the address bits plus the data bits. In byte mode (`org_word`=0) the address has ADDR_W+1 bits and the data has DATA_W/2 bits. In word mode (`org_word`=1) the address has ADDR_W bits and the data has DATA_W bits. With defaults, byte write is 18 and word write is 25.
- R4: Write (`op_class`=1) and write-all (4) carry data. If the count equals the expected length, `commit` is high for exactly one cycle, one cycle after the `cs_fall` strobe.
- R5: Erase (2), erase-all (3), write-enable (5) and write-disable (6) carry no data. With defaults they expect 10 clocks in byte mode and 9 in word mode, and they commit on an exact match.
- R6: For classes 1 to 6, any count other than the expected one, including expected plus one, gives a one-cycle `abort` one cycle after `cs_fall`.
- R7: A read frame (`op_class`=0), or the unused code 7, produces neither pulse.
- R8: The counter saturates and does not wrap. A frame of 73 clocks on a word-mode erase is aborted.
- R9: A `cs_fall` with no start bit since the previous `cs_fall` or reset produces neither pulse.
- R10: `commit` and `abort` are never high together. Either one is high only in the cycle right after a `cs_fall` strobe.
- R11: A serial-clock strobe in the same cycle as `cs_fall` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_rise | input | 1 | One-cycle strobe per serial-clock rising edge |
| start_bit | input | 1 | Marks the serial-clock strobe that samples the start bit |
| op_class | input | 3 | Decoded instruction class, valid with cs_fall |
| org_word | input | 1 | 1 = 16-bit word organization, 0 = byte |
| cs_fall | input | 1 | One-cycle strobe on the chip-select falling edge |
| commit | output | 1 | Frame length correct, program cycle may start |
| abort | output | 1 | Frame length wrong, instruction discarded |

## Verification
Each verdict comes from one register stage, so it is due in the cycle right after the `cs_fall` strobe is taken. The driver task drives inputs on falling clock edges. It pushes the expected verdict into a queue in the same cycle that it raises `cs_fall`. The monitor waits for the next rising edge and a short settle delay, then pops the queue and compares both outputs. In every other cycle the monitor requires both outputs to be low. Frame lengths are driven as exact-match, plus-one, minus-one and far-overlong counts.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_ERASE     = 3'd2,
        OP_ERASE_ALL = 3'd3,
        OP_WRITE_ALL = 3'd4,
        OP_WR_EN     = 3'd5,
        OP_WR_DIS    = 3'd6,
        OP_UNUSED    = 3'd7
    } op_class_e;

    // Longest frame among both organizations.
    function automatic int unsigned longest_frame(int unsigned addr_w, int unsigned data_w);
        int unsigned byte_len;
        int unsigned word_len;
        byte_len = 3 + addr_w + 1 + data_w / 2;
        word_len = 3 + addr_w + data_w;
        return (byte_len > word_len) ? byte_len : word_len;
    endfunction

endpackage

// File: rtl/ccc_expect.sv
module ccc_expect
    import ccc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 6
) (
    input  logic [2:0]       op_class,
    input  logic             org_word,
    output logic [CNT_W-1:0] exp_len,
    output logic             judged
);
    localparam int unsigned BYTE_BASE = 3 + ADDR_W + 1;
    localparam int unsigned WORD_BASE = 3 + ADDR_W;
    localparam int unsigned BYTE_DATA = DATA_W / 2;

    op_class_e op;
    logic      has_data;

    always_comb begin
        op       = op_class_e'(op_class);
        has_data = (op == OP_WRITE) || (op == OP_WRITE_ALL);
        judged   = (op != OP_READ) && (op != OP_UNUSED);
        if (org_word) begin
            exp_len = CNT_W'(WORD_BASE + (has_data ? DATA_W : 0));
        end else begin
            exp_len = CNT_W'(BYTE_BASE + (has_data ? BYTE_DATA : 0));
        end
    end

endmodule

// File: rtl/ccc_counter.sv
module ccc_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             start_bit,
    input  logic             cs_fall,
    output logic             armed,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (sclk_rise && start_bit) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_W'(1);
        end else if (sclk_rise && st_q.armed && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign count = st_q.cnt;

endmodule

// File: rtl/ccc_top.sv
module ccc_top
    import ccc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       start_bit,
    input  logic [2:0] op_class,
    input  logic       org_word,
    input  logic       cs_fall,
    output logic       commit,
    output logic       abort
);
    localparam int unsigned EXP_MAX = longest_frame(ADDR_W, DATA_W);
    localparam int unsigned CNT_W   = $clog2(EXP_MAX + 1) + 1;

    typedef struct packed {
        logic commit;
        logic abort;
    } verdict_t;

    logic             armed;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] exp_len;
    logic             judged;
    verdict_t         vd_d, vd_q;

    ccc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .start_bit (start_bit),
        .cs_fall   (cs_fall),
        .armed     (armed),
        .count     (count)
    );

    ccc_expect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_exp (
        .op_class (op_class),
        .org_word (org_word),
        .exp_len  (exp_len),
        .judged   (judged)
    );

    always_comb begin
        vd_d        = '0;
        if (cs_fall && armed && judged) begin
            vd_d.commit = (count == exp_len);
            vd_d.abort  = (count != exp_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign commit = vd_q.commit;
    assign abort  = vd_q.abort;

endmodule

// File: rtl/ccc_checker.sv
module ccc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_class,
    input logic       cs_fall,
    input logic       commit,
    input logic       abort
);
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && abort));

    assert_after_csfall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || abort) |-> $past(cs_fall));

    assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    assert_read_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && (op_class == 3'd0)) |=> !(commit || abort));

endmodule

bind ccc_top ccc_checker u_ccc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .cs_fall  (cs_fall),
    .commit   (commit),
    .abort    (abort)
);

// File: tb/ccc_top_tb_top.sv
module ccc_top_tb_top;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;

    typedef struct {
        bit    c;
        bit    a;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_rise = 1'b0;
    logic       start_bit = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic       org_word = 1'b0;
    logic       cs_fall = 1'b0;
    logic       commit;
    logic       abort;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ccc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .start_bit (start_bit),
        .op_class  (op_class),
        .org_word  (org_word),
        .cs_fall   (cs_fall),
        .commit    (commit),
        .abort     (abort)
    );

    function automatic int frame_len(int op, bit org);
        int data = (op == 1 || op == 4) ? (org ? DATA_W : DATA_W / 2) : 0;
        int addr = org ? ADDR_W : ADDR_W + 1;
        return 1 + 2 + addr + data;
    endfunction

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sclk_rise = 1'b1;
            @(negedge clk) sclk_rise = 1'b0;
        end
    endtask

    // Driver: frame of nclk serial clocks (first carries the start bit),
    // then chip-select fall; pushes the expected verdict.
    task automatic send(int op, bit org, int nclk, bit clk_at_cs, string tag);
        exp_t e;
        for (int i = 0; i < nclk; i++) begin
            @(negedge clk);
            sclk_rise = 1'b1;
            start_bit = (i == 0);
            @(negedge clk);
            sclk_rise = 1'b0;
            start_bit = 1'b0;
        end
        @(negedge clk);
        op_class  = 3'(op);
        org_word  = org;
        cs_fall   = 1'b1;
        sclk_rise = clk_at_cs;
        e.tag = tag;
        if (nclk == 0 || op == 0 || op == 7) begin
            e.c = 1'b0; e.a = 1'b0;
        end else begin
            e.c = (nclk == frame_len(op, org));
            e.a = !e.c;
        end
        sb.push_back(e);
        @(negedge clk);
        cs_fall   = 1'b0;
        sclk_rise = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: the verdict is due one rising edge after cs_fall is taken.
    always @(posedge clk) begin
        bit due;
        due = (cs_fall === 1'b1) && (rst_n === 1'b1);
        #1;
        if (due) begin
            exp_t e;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10: verdict due with empty scoreboard");
            end else begin
                e = sb.pop_front();
                checks++;
                if (commit !== e.c || abort !== e.a) begin
                    fails++;
                    $display("FAIL %s: commit/abort = %b%b, expected %b%b",
                             e.tag, commit, abort, e.c, e.a);
                end
            end
        end else if (rst_n === 1'b1 && (commit !== 1'b0 || abort !== 1'b0)) begin
            fails++;
            $display("FAIL R10: pulse outside verdict slot, commit/abort = %b%b, expected 00",
                     commit, abort);
        end
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (commit !== 1'b0 || abort !== 1'b0) begin
            fails++;
            $display("FAIL R1: during reset commit/abort = %b%b, expected 00", commit, abort);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (commit !== 1'b0 || abort !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset commit/abort = %b%b, expected 00", commit, abort);
        end

        // R3 R4: data-carrying instructions, exact length
        send(1, 1'b0, 18, 1'b0, "R4 byte write 18");
        send(1, 1'b1, 25, 1'b0, "R4 word write 25");
        send(4, 1'b0, 18, 1'b0, "R4 byte write-all 18");
        send(4, 1'b1, 25, 1'b0, "R3 word write-all 25");
        // R5: no-data instructions
        send(2, 1'b0, 10, 1'b0, "R5 byte erase 10");
        send(2, 1'b1, 9,  1'b0, "R5 word erase 9");
        send(3, 1'b1, 9,  1'b0, "R5 word erase-all 9");
        send(5, 1'b0, 10, 1'b0, "R5 byte write-enable 10");
        send(6, 1'b1, 9,  1'b0, "R5 word write-disable 9");
        // R6: mismatches
        send(1, 1'b0, 19, 1'b0, "R6 byte write plus one");
        send(1, 1'b1, 24, 1'b0, "R6 word write minus one");
        send(2, 1'b1, 10, 1'b0, "R6 word erase plus one");
        send(4, 1'b0, 17, 1'b0, "R6 byte write-all minus one");
        // R7: reads and unused code
        send(0, 1'b0, 18, 1'b0, "R7 read byte");
        send(0, 1'b1, 40, 1'b0, "R7 read stream");
        send(7, 1'b1, 9,  1'b0, "R7 unused code");
        // R2: stray clocks before the start bit are not counted
        pulses(5);
        send(2, 1'b0, 10, 1'b0, "R2 erase after stray clocks");
        // R9: chip-select fall with no start bit
        send(1, 1'b0, 0, 1'b0, "R9 cs fall without start");
        pulses(3);
        send(2, 1'b1, 0, 1'b0, "R9 clocks but no start");
        // R8: saturation, 73 = 64 + 9 would match if wrapped
        send(2, 1'b1, 73, 1'b0, "R8 saturated word erase");
        // R11: serial clock coincident with cs_fall is not counted
        send(2, 1'b1, 9, 1'b1, "R11 clock at cs fall");
        send(1, 1'b0, 18, 1'b1, "R11 write clock at cs fall");

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R10: %0d verdicts never observed, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule